// File: doc/BRIEF.md
# Accumulating Horizontal Video Subsampler

This block shrinks a video line horizontally by a whole-number factor. It receives 8-bit luma and two 8-bit chroma samples per pixel, in full-resolution 4:4:4 form, together with a qualifier that marks valid pixels. It adds up a run of consecutive valid pixels on each of the three components in parallel. For each run it produces one output pixel, scaled back to unity gain by a programmable multiply-and-shift normalizer and then clamped to the 8-bit range.

The run length is set by a static ratio code c, which gives a decimation factor N = c + 1, from 1 to 64. A second static bit selects how neighbouring runs relate. Runs can stand side by side, each holding N pixels. They can also overlap, each holding N + 1 pixels, with the last pixel of one run reused as the first pixel of the next. The overlap gives a slightly longer, smoother filter at the same output rate. A line-start strobe restarts the accumulation at the beginning of each video line. A new output qualifier marks only the cycles that carry a subsampled pixel.

Top module: `hrun_decimator`

## Requirements
- R1: While rstN is low, and after the clock edge that samples it low, outValid, outY, outU and outV are all 0.
- R2: With cfgNoOverlap = 1 and ratio code c, N = c + 1. Accepted pixels are grouped into disjoint runs of N, counted from line start, and each complete run yields exactly one output pixel built from the sum of its N samples.
- R3: With cfgNoOverlap = 0, each run holds N + 1 accepted pixels, and run k covers pixels k·N through k·N + N of the line. The boundary pixel therefore contributes to two consecutive outputs.
- R4: With code 0, cfgNoOverlap = 1, both multipliers 1 and both shifts 0, every accepted pixel is reproduced unchanged on the output.
- R5: A cycle with inValid low changes neither the running sums nor the run position, so gaps between valid pixels do not alter any output value.
- R6: lineStart discards any partial run. A valid pixel presented in the same cycle as lineStart becomes the first pixel of the new line.
- R7: Each output component equals (sum × mult + half) >> shift, where half is 2^(shift−1) for shift > 0 and 0 otherwise. Y uses cfgLumaMult/cfgLumaShift, and U and V use cfgChromaMult/cfgChromaShift.
- R8: A normalized value above 255 is output as 255.
- R9: Suppose the final pixel of a run is accepted at rising edge k. outValid is then high for exactly the one cycle after edge k+1, with the result on outY/outU/outV, and it is low in all other cycles.
- R10: A 65-pixel run of full-scale samples (code 63, cfgNoOverlap = 0) sums to 16575 without wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Synchronous active-low reset |
| lineStart | input | 1 | Start of a new video line; clears any partial run |
| inValid | input | 1 | Input pixel qualifier |
| inY | input | 8 | Input luma sample |
| inU | input | 8 | Input first chroma sample |
| inV | input | 8 | Input second chroma sample |
| cfgRatio | input | 6 | Ratio code c, decimation factor N = c + 1 |
| cfgNoOverlap | input | 1 | 1: disjoint runs of N; 0: overlapping runs of N + 1 |
| cfgLumaMult | input | 8 | Luma gain multiplier |
| cfgLumaShift | input | 4 | Luma gain right shift |
| cfgChromaMult | input | 8 | Chroma gain multiplier |
| cfgChromaShift | input | 4 | Chroma gain right shift |
| outValid | output | 1 | Output pixel qualifier |
| outY | output | 8 | Subsampled luma |
| outU | output | 8 | Subsampled first chroma |
| outV | output | 8 | Subsampled second chroma |

## Verification
If the run counter drifts by one pixel, the outputs keep their pacing but carry sums of the wrong pixels. On a ramp this shows up as a value offset at the very first output of a line. An accumulator that is left uncleared shows up on the first output after a line start as a value too large, often clamped to 255. A wrong seed in overlap mode is visible from the second output of the line, whose value is one boundary sample off. A qualifier fault breaks the fixed two-edge delay from the closing pixel to outValid. It is therefore seen on the first run of any line.

// File: rtl/hrun_pkg.sv
package hrun_pkg;

  localparam int NUM_CH  = 3;
  localparam int LUMA_CH = 0;

  // Strobes from the run control to the datapath, valid in the current cycle
  typedef struct packed {
    logic clearAcc;   // line start: forget the partial run
    logic addPix;     // accept the presented pixel
    logic closeWin;   // presented pixel completes a run
    logic seedNext;   // presented pixel also opens the next run
  } hrun_strobe_t;

endpackage

// File: rtl/hrun_ctrl.sv
module hrun_ctrl
  import hrun_pkg::*;
#(
  parameter int CODE_W = 6,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineStart,
  input  logic              inValid,
  input  logic [CODE_W-1:0] cfgRatio,
  input  logic              cfgNoOverlap,
  output hrun_strobe_t      strobe
);

  logic [CNT_W-1:0] tapCnt;
  logic [CNT_W-1:0] baseCnt;
  logic [CNT_W-1:0] nextCnt;
  logic [CNT_W-1:0] tapTarget;
  logic             closeNow;

  always_comb begin
    // taps per run: N + 1 - noOverlap = code + 2 - noOverlap
    tapTarget = CNT_W'(cfgRatio) + CNT_W'(2) - CNT_W'(cfgNoOverlap);
    baseCnt   = lineStart ? '0 : tapCnt;
    nextCnt   = baseCnt + CNT_W'(1);
    closeNow  = inValid && (nextCnt >= tapTarget);

    strobe.clearAcc = lineStart;
    strobe.addPix   = inValid;
    strobe.closeWin = closeNow;
    strobe.seedNext = closeNow && !cfgNoOverlap;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tapCnt <= '0;
    end else if (closeNow) begin
      tapCnt <= cfgNoOverlap ? CNT_W'(0) : CNT_W'(1);
    end else if (inValid) begin
      tapCnt <= nextCnt;
    end else begin
      tapCnt <= baseCnt;
    end
  end

endmodule

// File: rtl/hrun_norm.sv
module hrun_norm #(
  parameter int ACC_W   = 15,
  parameter int MULT_W  = 8,
  parameter int SHIFT_W = 4,
  parameter int PIX_W   = 8
) (
  input  logic [ACC_W-1:0]   sum,
  input  logic [MULT_W-1:0]  mult,
  input  logic [SHIFT_W-1:0] shift,
  output logic [PIX_W-1:0]   pix
);

  localparam int PROD_W = ACC_W + MULT_W;
  localparam int MAXV   = (1 << PIX_W) - 1;

  logic [PROD_W-1:0] prod;
  logic [PROD_W:0]   half;
  logic [PROD_W:0]   rounded;
  logic [PROD_W:0]   scaled;

  always_comb begin
    prod    = PROD_W'(sum) * PROD_W'(mult);
    half    = (shift == '0) ? '0 : ((PROD_W+1)'(1) << (shift - SHIFT_W'(1)));
    rounded = {1'b0, prod} + half;
    scaled  = rounded >> shift;
    if (scaled > (PROD_W+1)'(MAXV)) begin
      pix = PIX_W'(MAXV);
    end else begin
      pix = scaled[PIX_W-1:0];
    end
  end

endmodule

// File: rtl/hrun_datapath.sv
module hrun_datapath
  import hrun_pkg::*;
#(
  parameter int PIX_W   = 8,
  parameter int ACC_W   = 15,
  parameter int MULT_W  = 8,
  parameter int SHIFT_W = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  hrun_strobe_t                   strobe,
  input  logic [NUM_CH-1:0][PIX_W-1:0]   inPix,
  input  logic [MULT_W-1:0]              lumaMult,
  input  logic [SHIFT_W-1:0]             lumaShift,
  input  logic [MULT_W-1:0]              chromaMult,
  input  logic [SHIFT_W-1:0]             chromaShift,
  output logic                           stageValid,
  output logic                           outValid,
  output logic [NUM_CH-1:0][PIX_W-1:0]   outPix
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageValid <= 1'b0;
      outValid   <= 1'b0;
    end else begin
      stageValid <= strobe.addPix && strobe.closeWin;
      outValid   <= stageValid;
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [ACC_W-1:0]   acc;
    logic [ACC_W-1:0]   baseAcc;
    logic [ACC_W-1:0]   winSum;
    logic [ACC_W-1:0]   sumReg;
    logic [MULT_W-1:0]  gainMult;
    logic [SHIFT_W-1:0] gainShift;
    logic [PIX_W-1:0]   normPix;

    if (ch == LUMA_CH) begin : g_luma
      assign gainMult  = lumaMult;
      assign gainShift = lumaShift;
    end else begin : g_chroma
      assign gainMult  = chromaMult;
      assign gainShift = chromaShift;
    end

    always_comb begin
      baseAcc = strobe.clearAcc ? '0 : acc;
      winSum  = baseAcc + ACC_W'(inPix[ch]);
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        acc    <= '0;
        sumReg <= '0;
      end else if (strobe.addPix) begin
        if (strobe.closeWin) begin
          acc    <= strobe.seedNext ? ACC_W'(inPix[ch]) : '0;
          sumReg <= winSum;
        end else begin
          acc <= winSum;
        end
      end else begin
        acc <= baseAcc;
      end
    end

    hrun_norm #(
      .ACC_W  (ACC_W),
      .MULT_W (MULT_W),
      .SHIFT_W(SHIFT_W),
      .PIX_W  (PIX_W)
    ) u_norm (
      .sum  (sumReg),
      .mult (gainMult),
      .shift(gainShift),
      .pix  (normPix)
    );

    always_ff @(posedge clk) begin
      if (!rstN) begin
        outPix[ch] <= '0;
      end else if (stageValid) begin
        outPix[ch] <= normPix;
      end
    end
  end

endmodule

// File: rtl/hrun_decimator.sv
module hrun_decimator
  import hrun_pkg::*;
#(
  parameter int PIX_W   = 8,
  parameter int CODE_W  = 6,
  parameter int MULT_W  = 8,
  parameter int SHIFT_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lineStart,
  input  logic               inValid,
  input  logic [PIX_W-1:0]   inY,
  input  logic [PIX_W-1:0]   inU,
  input  logic [PIX_W-1:0]   inV,
  input  logic [CODE_W-1:0]  cfgRatio,
  input  logic               cfgNoOverlap,
  input  logic [MULT_W-1:0]  cfgLumaMult,
  input  logic [SHIFT_W-1:0] cfgLumaShift,
  input  logic [MULT_W-1:0]  cfgChromaMult,
  input  logic [SHIFT_W-1:0] cfgChromaShift,
  output logic               outValid,
  output logic [PIX_W-1:0]   outY,
  output logic [PIX_W-1:0]   outU,
  output logic [PIX_W-1:0]   outV
);

  localparam int MAX_TAPS = (1 << CODE_W) + 1;
  localparam int ACC_W    = $clog2(MAX_TAPS * ((1 << PIX_W) - 1) + 1);
  localparam int CNT_W    = $clog2(MAX_TAPS + 1);

  hrun_strobe_t                 strobe;
  logic [NUM_CH-1:0][PIX_W-1:0] inPix;
  logic [NUM_CH-1:0][PIX_W-1:0] outPix;
  logic                         stageValid;

  assign inPix[0] = inY;
  assign inPix[1] = inU;
  assign inPix[2] = inV;

  hrun_ctrl #(
    .CODE_W(CODE_W),
    .CNT_W (CNT_W)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .lineStart   (lineStart),
    .inValid     (inValid),
    .cfgRatio    (cfgRatio),
    .cfgNoOverlap(cfgNoOverlap),
    .strobe      (strobe)
  );

  hrun_datapath #(
    .PIX_W  (PIX_W),
    .ACC_W  (ACC_W),
    .MULT_W (MULT_W),
    .SHIFT_W(SHIFT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .inPix      (inPix),
    .lumaMult   (cfgLumaMult),
    .lumaShift  (cfgLumaShift),
    .chromaMult (cfgChromaMult),
    .chromaShift(cfgChromaShift),
    .stageValid (stageValid),
    .outValid   (outValid),
    .outPix     (outPix)
  );

  assign outY = outPix[0];
  assign outU = outPix[1];
  assign outV = outPix[2];

endmodule

// File: rtl/hrun_checker.sv
module hrun_checker #(
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              lineStart,
  input logic              inValid,
  input logic [CODE_W-1:0] cfgRatio,
  input logic              cfgNoOverlap,
  input logic              stageValid,
  input logic              outValid
);

  // R9: every output pixel traces back to a pixel accepted two edges earlier
  a_r9_out_from_pixel: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid, 2));

  // R9: a closed run always reaches the output one edge later
  a_r9_pipe_advance: assert property (@(posedge clk) disable iff (!rstN)
    stageValid |=> outValid);

  // R2: with N of two or more, output pulses never touch
  a_r2_isolated_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && cfgRatio != '0) |=> !outValid);

  // R4: true bypass closes a run on every accepted pixel
  a_r4_bypass_each: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && cfgRatio == '0 && cfgNoOverlap) |=> stageValid);

  // R5: an idle cycle never completes a run
  a_r5_idle_no_close: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !stageValid);

  // R6: a line start restarts counting, so no run can complete on it when N > 1
  a_r6_line_restart: assert property (@(posedge clk) disable iff (!rstN)
    (lineStart && cfgRatio != '0) |=> !stageValid);

endmodule

bind hrun_decimator hrun_checker #(.CODE_W(CODE_W)) u_hrun_chk (
  .clk         (clk),
  .rstN        (rstN),
  .lineStart   (lineStart),
  .inValid     (inValid),
  .cfgRatio    (cfgRatio),
  .cfgNoOverlap(cfgNoOverlap),
  .stageValid  (stageValid),
  .outValid    (outValid)
);

// File: tb/hrun_decimator_bench.sv
module hrun_decimator_bench;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [5:0] ratio;
    logic       noOv;
    logic [7:0] lm;
    logic [3:0] ls;
    logic [7:0] cm;
    logic [3:0] cs;
    logic [7:0] y0;
    logic [7:0] dy;
    logic [7:0] u0;
    logic [7:0] v0;
    logic [7:0] npix;
    logic [3:0] gap;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{6'd0,  1'b1, 8'd1,   4'd0, 8'd1,   4'd0, 8'd10,  8'd7, 8'd100, 8'd200, 8'd8,  4'd0},
    '{6'd3,  1'b1, 8'd64,  4'd8, 8'd128, 4'd9, 8'd0,   8'd9, 8'd50,  8'd77,  8'd16, 4'd3},
    '{6'd2,  1'b0, 8'd64,  4'd8, 8'd64,  4'd8, 8'd20,  8'd5, 8'd30,  8'd90,  8'd13, 4'd2},
    '{6'd1,  1'b1, 8'd255, 4'd0, 8'd3,   4'd2, 8'd100, 8'd0, 8'd5,   8'd0,   8'd6,  4'd0},
    '{6'd63, 1'b0, 8'd1,   4'd7, 8'd1,   4'd7, 8'd255, 8'd0, 8'd0,   8'd255, 8'd65, 4'd0},
    '{6'd4,  1'b0, 8'd51,  4'd8, 8'd43,  4'd8, 8'd3,   8'd11, 8'd7,  8'd140, 8'd14, 4'd1}
  };

  logic       clk = 1'b0;
  logic       rstN;
  logic       lineStart;
  logic       inValid;
  logic [7:0] inY, inU, inV;
  logic [5:0] cfgRatio;
  logic       cfgNoOverlap;
  logic [7:0] cfgLumaMult, cfgChromaMult;
  logic [3:0] cfgLumaShift, cfgChromaShift;
  logic       outValid;
  logic [7:0] outY, outU, outV;

  int errors = 0;
  int checks = 0;
  int expCnt = 0;
  int gotCnt = 0;
  int expY [0:63];
  int expU [0:63];
  int expV [0:63];
  string curReq = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  hrun_decimator u_hrun_decimator (
    .clk           (clk),
    .rstN          (rstN),
    .lineStart     (lineStart),
    .inValid       (inValid),
    .inY           (inY),
    .inU           (inU),
    .inV           (inV),
    .cfgRatio      (cfgRatio),
    .cfgNoOverlap  (cfgNoOverlap),
    .cfgLumaMult   (cfgLumaMult),
    .cfgLumaShift  (cfgLumaShift),
    .cfgChromaMult (cfgChromaMult),
    .cfgChromaShift(cfgChromaShift),
    .outValid      (outValid),
    .outY          (outY),
    .outU          (outU),
    .outV          (outV)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int normExp(input int sum, input int mult, input int sh);
    int r;
    r = sum * mult;
    if (sh > 0) r = r + (1 << (sh - 1));
    r = r >>> sh;
    if (r > 255) r = 255;
    return r;
  endfunction

  // Output monitor: compares each qualified output with the next expected pixel (R9 pacing)
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (gotCnt < expCnt) begin
        check(curReq, "outY", int'(outY), expY[gotCnt]);
        check(curReq, "outU", int'(outU), expU[gotCnt]);
        check(curReq, "outV", int'(outV), expV[gotCnt]);
      end else begin
        check("R9", "unexpected outValid index", gotCnt, expCnt - 1);
      end
      gotCnt++;
    end
  end

  task automatic drive(input logic v, input logic ls, input int y, input int u, input int w);
    @(negedge clk);
    inValid   = v;
    lineStart = ls;
    inY       = 8'(y);
    inU       = 8'(u);
    inV       = 8'(w);
  endtask

  task automatic finishRun(input string req);
    drive(1'b0, 1'b0, 0, 0, 0);
    repeat (5) @(negedge clk);
    check(req, "output count", gotCnt, expCnt);
  endtask

  task automatic runVec(input int idx, input string req);
    vec_t vc;
    int   n, taps, w, s, sy, su, sv;
    int   py [0:255];
    int   pu [0:255];
    int   pv [0:255];
    vc = VECS[idx];
    @(negedge clk);
    cfgRatio       = vc.ratio;
    cfgNoOverlap   = vc.noOv;
    cfgLumaMult    = vc.lm;
    cfgLumaShift   = vc.ls;
    cfgChromaMult  = vc.cm;
    cfgChromaShift = vc.cs;
    curReq = req;
    gotCnt = 0;
    for (int i = 0; i < int'(vc.npix); i++) begin
      py[i] = (int'(vc.y0) + i * int'(vc.dy)) & 255;
      pu[i] = (int'(vc.u0) + i) & 255;
      pv[i] = int'(vc.v0);
    end
    n    = int'(vc.ratio) + 1;
    taps = n + (vc.noOv ? 0 : 1);
    w    = 0;
    s    = 0;
    while (s + taps - 1 < int'(vc.npix)) begin
      sy = 0; su = 0; sv = 0;
      for (int k = 0; k < taps; k++) begin
        sy += py[s + k];
        su += pu[s + k];
        sv += pv[s + k];
      end
      expY[w] = normExp(sy, int'(vc.lm), int'(vc.ls));
      expU[w] = normExp(su, int'(vc.cm), int'(vc.cs));
      expV[w] = normExp(sv, int'(vc.cm), int'(vc.cs));
      w++;
      s += n;
    end
    expCnt = w;
    drive(1'b0, 1'b1, 0, 0, 0);
    for (int i = 0; i < int'(vc.npix); i++) begin
      drive(1'b1, 1'b0, py[i], pu[i], pv[i]);
      if (vc.gap != 0 && (i % int'(vc.gap)) == int'(vc.gap) - 1) begin
        drive(1'b0, 1'b0, 255, 255, 255);  // R5: junk data while idle
      end
    end
    finishRun(req);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    lineStart = 1'b0;
    inValid = 1'b1;
    inY = 8'd200; inU = 8'd200; inV = 8'd200;
    cfgRatio = '0; cfgNoOverlap = 1'b1;
    cfgLumaMult = 8'd1; cfgLumaShift = '0;
    cfgChromaMult = 8'd1; cfgChromaShift = '0;
    repeat (3) @(negedge clk);
    // R1: reset state even with a bypass-configured pixel stream present
    check("R1", "outValid in reset", int'(outValid), 0);
    check("R1", "outY in reset", int'(outY), 0);
    check("R1", "outU in reset", int'(outU), 0);
    check("R1", "outV in reset", int'(outV), 0);
    inValid = 1'b0;
    @(negedge clk);
    rstN = 1'b1;

    runVec(0, "R4");
    runVec(1, "R2 R5 R7");
    runVec(2, "R3");
    runVec(3, "R8 R7");
    runVec(4, "R10");
    runVec(5, "R3 R5");

    // R6: partial run of large pixels is dropped; pixel beside lineStart opens the new line
    @(negedge clk);
    cfgRatio = 6'd3; cfgNoOverlap = 1'b1;
    cfgLumaMult = 8'd64; cfgLumaShift = 4'd8;
    cfgChromaMult = 8'd64; cfgChromaShift = 4'd8;
    curReq = "R6";
    gotCnt = 0;
    expCnt = 1;
    expY[0] = 8; expU[0] = 8; expV[0] = 8;
    drive(1'b0, 1'b1, 0, 0, 0);
    for (int i = 0; i < 3; i++) drive(1'b1, 1'b0, 200, 200, 200);
    drive(1'b1, 1'b1, 8, 8, 8);
    for (int i = 0; i < 3; i++) drive(1'b1, 1'b0, 8, 8, 8);
    finishRun("R6");

    // R9: output qualifier appears exactly one cycle after the edge following the closing pixel
    @(negedge clk);
    cfgRatio = 6'd1; cfgNoOverlap = 1'b1;
    cfgLumaMult = 8'd1; cfgLumaShift = 4'd1;
    cfgChromaMult = 8'd1; cfgChromaShift = 4'd1;
    curReq = "R9";
    gotCnt = 0;
    expCnt = 1;
    expY[0] = 41; expU[0] = 41; expV[0] = 41;
    drive(1'b0, 1'b1, 0, 0, 0);
    drive(1'b1, 1'b0, 40, 40, 40);
    drive(1'b1, 1'b0, 41, 41, 41);
    drive(1'b0, 1'b0, 0, 0, 0);
    check("R9", "outValid one edge after close", int'(outValid), 0);
    @(negedge clk);
    check("R9", "outValid two edges after close", int'(outValid), 1);
    @(negedge clk);
    check("R9", "outValid pulse width", int'(outValid), 0);
    finishRun("R9");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule